// File: doc/BRIEF.md
# Push-Button Light Toggle Controller

This block drives a single light from a single push-button. One complete click, meaning a press followed by a release, turns the light on. The next complete click turns it off. The button input must already be synchronised to the clock and free of bounce. A button held down for any number of cycles counts as one click.

The controller is a four-state machine with one-hot encoding. Two of its states are stable: light off and light on. The other two record that a press has been seen and the release is still awaited. The light output is decoded directly from the state register. The new level therefore appears at the same edge that first samples the button pressed.

Reset is asynchronous and active low. It is released synchronously through a two-stage synchroniser inside the block. Any state-register value that is not one-hot is steered back to the off state at the next edge.

Top module: `light_toggle_ctrl`

## Requirements
- R1: While `rst_n` is low, `light_o` is 0 without waiting for a clock edge. Once the reset is released and the button stays up, the light remains 0.
- R2: With the light off and the block idle, the first rising clock edge that samples `btn_i` = 1 sets `light_o` to 1.
- R3: After turning on, the light stays 1 for as long as the button is held, however many cycles that is. It is still 1 after the release.
- R4: With the light steadily on, the first edge that samples `btn_i` = 1 clears `light_o` to 0. It stays 0 while the button is held and after the release.
- R5: While `btn_i` stays 0, the light keeps its level in both the off and the on condition.
- R6: After any sequence of complete clicks, `light_o` equals the parity of the click count. A one-cycle press counts as a full click. The state register always holds exactly one set bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| btn_i | input | 1 | Push-button level, 1 = pressed, already synchronised and debounced |
| light_o | output | 1 | Light drive, 1 = on |

## Verification
The bench holds the button down for long stretches, up to a few hundred cycles, in both the turning-on and the turning-off phase. A design that toggled on raw level rather than on a completed click would flicker there or end in the wrong level. It also uses single-cycle presses, where a design that needed the release to be seen in a separate state for more than one cycle would lose clicks. Odd and even click counts are compared against the expected parity. A reset is applied while the light is on, and a design with a synchronous-only clear would keep the light lit until the next edge.

// File: rtl/light_toggle_pkg.sv
package light_toggle_pkg;
  localparam int NUM_STATES = 4;

  localparam int IDX_OFF      = 0;
  localparam int IDX_ARM_ON   = 1;
  localparam int IDX_LIT      = 2;
  localparam int IDX_ARM_OFF  = 3;

  typedef logic [NUM_STATES-1:0] state_t;

  localparam state_t ST_OFF     = state_t'(1) << IDX_OFF;
  localparam state_t ST_ARM_ON  = state_t'(1) << IDX_ARM_ON;
  localparam state_t ST_LIT     = state_t'(1) << IDX_LIT;
  localparam state_t ST_ARM_OFF = state_t'(1) << IDX_ARM_OFF;
endpackage

// File: rtl/light_toggle_rst_sync.sv
module light_toggle_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/light_toggle_next.sv
module light_toggle_next
  import light_toggle_pkg::*;
(
  input  state_t state_i,
  input  logic   btn_i,
  output state_t state_o
);
  always_comb begin
    case (state_i)
      ST_OFF:     state_o = btn_i ? ST_ARM_ON : ST_OFF;
      ST_ARM_ON:  state_o = btn_i ? ST_ARM_ON : ST_LIT;
      ST_LIT:     state_o = btn_i ? ST_ARM_OFF : ST_LIT;
      ST_ARM_OFF: state_o = btn_i ? ST_ARM_OFF : ST_OFF;
      default:    state_o = ST_OFF;
    endcase
  end
endmodule

// File: rtl/light_toggle_state_reg.sv
module light_toggle_state_reg #(
  parameter int                 WIDTH   = 4,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= RST_VAL;
    end else if (en_i) begin
      q_o <= d_i;
    end
  end
endmodule

// File: rtl/light_toggle_out.sv
module light_toggle_out
  import light_toggle_pkg::*;
(
  input  state_t state_i,
  output logic   light_o
);
  assign light_o = state_i[IDX_ARM_ON] | state_i[IDX_LIT];
endmodule

// File: rtl/light_toggle_ctrl.sv
module light_toggle_ctrl
  import light_toggle_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic light_o
);
  logic   rst_sync_n;
  state_t state_q;
  state_t state_d;
  logic   state_en;

  light_toggle_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  light_toggle_next u_next (
    .state_i (state_q),
    .btn_i   (btn_i),
    .state_o (state_d)
  );

  assign state_en = (state_d != state_q);

  light_toggle_state_reg #(
    .WIDTH   (NUM_STATES),
    .RST_VAL (ST_OFF)
  ) u_state (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_i  (state_en),
    .d_i   (state_d),
    .q_o   (state_q)
  );

  light_toggle_out u_out (
    .state_i (state_q),
    .light_o (light_o)
  );
endmodule

// File: rtl/light_toggle_chk.sv
module light_toggle_chk
  import light_toggle_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   rst_sync_n,
  input logic   btn,
  input logic   light,
  input state_t state
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_off_in_reset_R1: assert (light == 1'b0);
    end
  end

  assert_press_lights_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state[IDX_OFF] && btn) |=> light);

  assert_hold_keeps_on_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state[IDX_ARM_ON] && btn) |=> (light && state[IDX_ARM_ON]));

  assert_press_darkens_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state[IDX_LIT] && btn) |=> !light);

  assert_released_on_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!btn && light) |=> light);

  assert_released_off_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!btn && !light) |=> !light);

  assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(state) == 1);
endmodule

bind light_toggle_ctrl light_toggle_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .btn        (btn_i),
  .light      (light_o),
  .state      (state_q)
);

// File: tb/light_toggle_ctrl_tb.sv
`timescale 1ns/1ps
module light_toggle_ctrl_tb;
  logic clk;
  logic rst_n;
  logic btn_i;
  logic light_o;

  int n_checks;
  int n_fails;
  int cycles;

  light_toggle_ctrl u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .btn_i   (btn_i),
    .light_o (light_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic exp, input string req, input string what);
    n_checks++;
    if (light_o !== exp) begin
      n_fails++;
      $display("FAIL %s %s: light_o=%b expected=%b", req, what, light_o, exp);
    end
  endtask

  task automatic cycles_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    btn_i = 1'b0;
    rst_n = 1'b0;
    #1;
    check(1'b0, "R1", "during reset");
    cycles_n(3);
    check(1'b0, "R1", "reset held");
    rst_n = 1'b1;
    cycles_n(6);
    check(1'b0, "R1", "after release");
  endtask

  task automatic t_first_click(input int hold);
    btn_i = 1'b1;
    cycles_n(1);
    check(1'b1, "R2", "first edge with press");
    for (int i = 1; i < hold; i++) begin
      cycles_n(1);
      if (i % 37 == 0) check(1'b1, "R3", "holding after turn-on");
    end
    check(1'b1, "R3", "end of hold");
    btn_i = 1'b0;
    cycles_n(2);
    check(1'b1, "R3", "after release");
  endtask

  task automatic t_second_click(input int hold);
    btn_i = 1'b1;
    cycles_n(1);
    check(1'b0, "R4", "first edge with press");
    for (int i = 1; i < hold; i++) begin
      cycles_n(1);
      if (i % 41 == 0) check(1'b0, "R4", "holding after turn-off");
    end
    btn_i = 1'b0;
    cycles_n(2);
    check(1'b0, "R4", "after release");
  endtask

  task automatic t_quiet(input logic exp, input int n);
    btn_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      cycles_n(1);
      if (i % 10 == 9) check(exp, "R5", "button released idle");
    end
  endtask

  task automatic t_many_clicks(input int count);
    logic exp;
    exp = 1'b0;
    for (int k = 0; k < count; k++) begin
      btn_i = 1'b1;
      cycles_n(1 + (k * 7) % 13);
      btn_i = 1'b0;
      cycles_n(1 + k % 3);
      exp = ~exp;
      check(exp, "R6", "parity after click");
    end
  endtask

  task automatic t_short_clicks(input int count, input logic start);
    logic exp;
    exp = start;
    for (int k = 0; k < count; k++) begin
      btn_i = 1'b1;
      cycles_n(1);
      btn_i = 1'b0;
      cycles_n(1);
      exp = ~exp;
    end
    check(exp, "R6", "one-cycle clicks");
  endtask

  task automatic t_midreset();
    btn_i = 1'b1;
    cycles_n(1);
    btn_i = 1'b0;
    cycles_n(2);
    check(1'b1, "R1", "lit before reset");
    #2;
    rst_n = 1'b0;
    #1;
    check(1'b0, "R1", "async clear mid-cycle");
    cycles_n(2);
    rst_n = 1'b1;
    cycles_n(6);
    check(1'b0, "R1", "off after reset release");
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, 100000);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
      end
    end
  end

  initial begin
    n_checks = 0;
    n_fails = 0;
    rst_n = 1'b0;
    btn_i = 1'b0;
    @(negedge clk);
    do_reset();
    t_quiet(1'b0, 30);
    t_first_click(200);
    t_quiet(1'b1, 30);
    t_second_click(300);
    t_quiet(1'b0, 20);
    t_many_clicks(7);
    t_short_clicks(5, 1'b1);
    t_midreset();
    t_many_clicks(4);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule